// File: doc/BRIEF.md
# UART Status Flag and Interrupt Request Unit

This block holds the six status flags of one serial channel and turns them into a single interrupt request. A separate transmit engine and receive engine report events to it as one-cycle pulses:
- the transmit data has moved into the shift register;
- every queued byte has left the line;
- a stop bit has been detected, carrying that frame's parity and framing results.

The CPU side does three things:
- It writes a three-bit enable register.
- It reads the flags through a read port.
- It clears flags with strobes. These strobes come from a write of the transmit data register, a read of the receive data register, and a dedicated error-clear action.

The request line is a level. It stays high as long as an enabled flag is set. It is handed to the interrupt controller of the chip.

Two transmit conditions are kept apart, each with its own enable:
- "the buffer can take another byte";
- "the line has gone idle".

On the receive side, one enable covers data-full and all three error flags.

Top module: `uart_stat_irq`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, the flags read `stat_rd = 6'b010000` and `ctl_rd = 3'b000`, and `irq` is 0.
- R2: `stat_rd` bit map: bit0 receive full, bit1 overrun, bit2 parity error, bit3 framing error, bit4 transmit buffer empty, bit5 transmit complete. `ctl_wdata`/`ctl_rd` bit map: bit0 empty enable, bit1 complete enable, bit2 receive enable. These bits are loaded when `ctl_we` is high.
- R3: The transmit buffer empty flag is set by `ev_shift_load` and cleared by `clr_tx_write`. When both come in the same cycle, the flag is set.
- R4: The transmit complete flag is set by `ev_tx_done` and cleared by `clr_tx_write`. When both come in the same cycle, the flag is cleared.
- R5: Receive full is set by `ev_rx_stop` only when both `ev_rx_par_err` and `ev_rx_frm_err` are low. It is cleared by `clr_rx_read`, unless a good stop arrives in the same cycle.
- R6: Parity and framing error flags are set only in a cycle with `ev_rx_stop` high. `ev_rx_par_err` and `ev_rx_frm_err` have no effect without it.
- R7: `ev_rx_stop` while receive full is 1 and `clr_rx_read` is low sets overrun and leaves receive full at 1. With `clr_rx_read` in the same cycle, no overrun is flagged.
- R8: `clr_err` clears the overrun, parity and framing flags together. An error set in the same cycle wins over the clear.
- R9: `irq` = (empty & empty enable) | (complete & complete enable) | ((full | overrun | parity | framing) & receive enable). It follows the registered flags and enables without added delay.
- R10: All flag and enable updates take effect at the clock edge that samples the event or strobe, so `stat_rd`, `ctl_rd` and `irq` show them one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Enable register write strobe |
| ctl_wdata | input | 3 | Enable register write data |
| ev_shift_load | input | 1 | Transmit data moved to shift register |
| ev_tx_done | input | 1 | All queued transmit data sent |
| ev_rx_stop | input | 1 | Stop bit of a received frame detected |
| ev_rx_par_err | input | 1 | Parity result of the frame, valid with ev_rx_stop |
| ev_rx_frm_err | input | 1 | Framing result of the frame, valid with ev_rx_stop |
| clr_tx_write | input | 1 | CPU wrote the transmit data register |
| clr_rx_read | input | 1 | CPU read the receive data register |
| clr_err | input | 1 | CPU error-clear strobe |
| stat_rd | output | 6 | Flag read port |
| ctl_rd | output | 3 | Enable register read port |
| irq | output | 1 | Combined level interrupt request |

## Verification
The bench aims at the same-cycle collisions, where a design that orders set and clear the wrong way breaks:
- A write arriving together with a shift-register load must leave the buffer-empty flag set and transmit complete cleared. A swapped priority would leave the CPU waiting forever, or would report an idle line while data is queued.
- A read coinciding with a new stop bit must not flag an overrun. A wrong design would report lost data that was never lost, or would drop the new byte.
- Error strobes pulsed without a stop bit must leave the flags untouched, and an error-clear that collides with a fresh error must lose to it.
- Each enable is toggled alone to show the request follows only its own sources.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

    localparam int STAT_W = 6;
    localparam int CTL_W  = 3;

    // Flag vector, LSB = receive full.
    typedef struct packed {
        logic tx_cmp;
        logic tx_emp;
        logic frm;
        logic par;
        logic ovr;
        logic rx_full;
    } stat_t;

    // Enable vector, LSB = buffer-empty enable.
    typedef struct packed {
        logic rx_en;
        logic cmp_en;
        logic emp_en;
    } ctl_t;

    localparam stat_t STAT_RST = '{tx_cmp: 1'b0, tx_emp: 1'b1, frm: 1'b0,
                                   par: 1'b0, ovr: 1'b0, rx_full: 1'b0};

    typedef struct packed {
        logic stop;
        logic par_err;
        logic frm_err;
        logic rd_clr;
        logic err_clr;
    } rx_ev_t;

    function automatic logic rx_any(input stat_t s);
        return s.rx_full | s.ovr | s.par | s.frm;
    endfunction

endpackage

// File: rtl/uart_ctl_reg.sv
module uart_ctl_reg
    import uart_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl
);
    always_ff @(posedge clk) begin
        if (rst)     ctl <= '0;
        else if (we) ctl <= ctl_t'(wdata);
    end
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
    input  logic clk,
    input  logic rst,
    input  logic shift_load,
    input  logic tx_done,
    input  logic data_write,
    output logic emp,
    output logic cmp
);
    logic emp_n, cmp_n;

    always_comb begin
        // load after write: buffer free again, load wins
        emp_n = shift_load | (emp & ~data_write);
        // new data queued: line not idle, write wins
        cmp_n = ~data_write & (tx_done | cmp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            emp <= 1'b1;
            cmp <= 1'b0;
        end else begin
            emp <= emp_n;
            cmp <= cmp_n;
        end
    end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
    import uart_stat_pkg::*;
#(
    parameter int N_ERR = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  rx_ev_t           ev,
    output logic             full,
    output logic [N_ERR-1:0] err   // {framing, parity, overrun}
);
    logic             good;
    logic [N_ERR-1:0] err_set;

    assign good       = ev.stop & ~ev.par_err & ~ev.frm_err;
    assign err_set[0] = ev.stop & full & ~ev.rd_clr;
    assign err_set[1] = ev.stop & ev.par_err;
    assign err_set[2] = ev.stop & ev.frm_err;

    always_ff @(posedge clk) begin
        if (rst)             full <= 1'b0;
        else if (good)       full <= 1'b1;
        else if (ev.rd_clr)  full <= 1'b0;
    end

    for (genvar i = 0; i < N_ERR; i++) begin : g_err
        always_ff @(posedge clk) begin
            if (rst) err[i] <= 1'b0;
            else     err[i] <= err_set[i] | (err[i] & ~ev.err_clr);
        end
    end
endmodule

// File: rtl/uart_irq_merge.sv
module uart_irq_merge
    import uart_stat_pkg::*;
(
    input  stat_t stat,
    input  ctl_t  ctl,
    output logic  irq
);
    logic req_emp, req_cmp, req_rx;

    always_comb begin
        req_emp = stat.tx_emp & ctl.emp_en;
        req_cmp = stat.tx_cmp & ctl.cmp_en;
        req_rx  = rx_any(stat) & ctl.rx_en;
        irq     = req_emp | req_cmp | req_rx;
    end
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
    import uart_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              ev_shift_load,
    input  logic              ev_tx_done,
    input  logic              ev_rx_stop,
    input  logic              ev_rx_par_err,
    input  logic              ev_rx_frm_err,
    input  logic              clr_tx_write,
    input  logic              clr_rx_read,
    input  logic              clr_err,
    output logic [STAT_W-1:0] stat_rd,
    output logic [CTL_W-1:0]  ctl_rd,
    output logic              irq
);
    ctl_t        ctl;
    stat_t       stat;
    rx_ev_t      rx_ev;
    logic        emp, cmp, full;
    logic [2:0]  err;

    uart_ctl_reg u_ctl (
        .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata), .ctl(ctl)
    );

    uart_tx_flags u_tx (
        .clk(clk), .rst(rst), .shift_load(ev_shift_load), .tx_done(ev_tx_done),
        .data_write(clr_tx_write), .emp(emp), .cmp(cmp)
    );

    assign rx_ev = '{stop: ev_rx_stop, par_err: ev_rx_par_err,
                     frm_err: ev_rx_frm_err, rd_clr: clr_rx_read,
                     err_clr: clr_err};

    uart_rx_flags #(.N_ERR(3)) u_rx (
        .clk(clk), .rst(rst), .ev(rx_ev), .full(full), .err(err)
    );

    assign stat = '{tx_cmp: cmp, tx_emp: emp, frm: err[2], par: err[1],
                    ovr: err[0], rx_full: full};

    uart_irq_merge u_irq (.stat(stat), .ctl(ctl), .irq(irq));

    assign stat_rd = stat;
    assign ctl_rd  = ctl;
endmodule

// File: rtl/uart_stat_irq_chk.sv
module uart_stat_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_we,
    input logic [2:0] ctl_wdata,
    input logic       ev_shift_load,
    input logic       ev_tx_done,
    input logic       ev_rx_stop,
    input logic       ev_rx_par_err,
    input logic       ev_rx_frm_err,
    input logic       clr_tx_write,
    input logic       clr_rx_read,
    input logic       clr_err,
    input logic [5:0] stat_rd,
    input logic [2:0] ctl_rd,
    input logic       irq
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (stat_rd == 6'b010000 && ctl_rd == 3'b000));

    assert_load_sets_empty_R3: assert property (@(posedge clk) disable iff (rst)
        ev_shift_load |=> stat_rd[4]);

    assert_write_clears_cmp_R4: assert property (@(posedge clk) disable iff (rst)
        clr_tx_write |=> !stat_rd[5]);

    assert_err_only_at_stop_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(stat_rd[2]) || $rose(stat_rd[3])) |-> $past(ev_rx_stop));

    assert_overrun_keeps_full_R7: assert property (@(posedge clk) disable iff (rst)
        (ev_rx_stop && stat_rd[0] && !clr_rx_read) |=> (stat_rd[1] && stat_rd[0]));

    assert_no_enable_no_irq_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd == 3'b000) |-> !irq);

    assert_irq_rise_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ctl_we || ev_shift_load || ev_tx_done || ev_rx_stop));
endmodule

bind uart_stat_irq uart_stat_irq_chk u_chk (.*);

// File: tb/tb_uart_stat_irq.sv
module tb_uart_stat_irq;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_we;
    logic [2:0] ctl_wdata;
    logic       ev_shift_load, ev_tx_done, ev_rx_stop, ev_rx_par_err, ev_rx_frm_err;
    logic       clr_tx_write, clr_rx_read, clr_err;
    logic [5:0] stat_rd;
    logic [2:0] ctl_rd;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    uart_stat_irq dut (.*);

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // {ctl_rd, stat_rd, irq}
    function automatic logic [9:0] obs();
        return {ctl_rd, stat_rd, irq};
    endfunction

    task automatic idle();
        ctl_we = 0; ctl_wdata = 0; ev_shift_load = 0; ev_tx_done = 0;
        ev_rx_stop = 0; ev_rx_par_err = 0; ev_rx_frm_err = 0;
        clr_tx_write = 0; clr_rx_read = 0; clr_err = 0;
    endtask

    // inputs are held from one falling edge to the next
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic set_en(input logic [2:0] v);
        ctl_we = 1; ctl_wdata = v; step();
    endtask

    task automatic do_reset();
        rst = 1; idle(); step(); step(); rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset", obs(), {3'b000, 6'b010000, 1'b0});
    endtask

    task automatic t_tx();
        do_reset();
        set_en(3'b001);
        chk("R2 R9 empty enable raises irq", obs(), {3'b001, 6'b010000, 1'b1});
        clr_tx_write = 1; step();
        chk("R3 write clears empty", obs(), {3'b001, 6'b000000, 1'b0});
        ev_shift_load = 1; step();
        chk("R3 R10 load sets empty", obs(), {3'b001, 6'b010000, 1'b1});
        set_en(3'b010);
        chk("R9 complete enable alone, no complete", obs(), {3'b010, 6'b010000, 1'b0});
        ev_tx_done = 1; step();
        chk("R4 done sets complete", obs(), {3'b010, 6'b110000, 1'b1});
        clr_tx_write = 1; step();
        chk("R4 write clears both", obs(), {3'b010, 6'b000000, 1'b0});
    endtask

    task automatic t_tx_collide();
        do_reset();
        ev_tx_done = 1; step();
        clr_tx_write = 1; ev_shift_load = 1; step();
        chk("R3 R4 write+load: empty set, complete cleared", obs(), {3'b000, 6'b010000, 1'b0});
        clr_tx_write = 1; step();
        ev_tx_done = 1; clr_tx_write = 1; step();
        chk("R4 write wins over done", obs(), {3'b000, 6'b000000, 1'b0});
    endtask

    task automatic t_rx_good();
        do_reset();
        set_en(3'b100);
        chk("R9 rx enable, no rx flags", obs(), {3'b100, 6'b010000, 1'b0});
        ev_rx_stop = 1; step();
        chk("R5 good frame sets full", obs(), {3'b100, 6'b010001, 1'b1});
        set_en(3'b000);
        chk("R9 enable dropped removes irq", obs(), {3'b000, 6'b010001, 1'b0});
        set_en(3'b100);
        clr_rx_read = 1; step();
        chk("R5 read clears full", obs(), {3'b100, 6'b010000, 1'b0});
    endtask

    task automatic t_rx_err();
        do_reset();
        set_en(3'b100);
        ev_rx_par_err = 1; ev_rx_frm_err = 1; step();
        chk("R6 errors ignored without stop", obs(), {3'b100, 6'b010000, 1'b0});
        ev_rx_stop = 1; ev_rx_par_err = 1; step();
        chk("R6 parity at stop, no full", obs(), {3'b100, 6'b010100, 1'b1});
        ev_rx_stop = 1; ev_rx_frm_err = 1; step();
        chk("R6 framing at stop", obs(), {3'b100, 6'b011100, 1'b1});
        clr_err = 1; step();
        chk("R8 error clear", obs(), {3'b100, 6'b010000, 1'b0});
        ev_rx_stop = 1; ev_rx_frm_err = 1; step();
        clr_err = 1; ev_rx_stop = 1; ev_rx_par_err = 1; step();
        chk("R8 new parity beats clear, framing cleared", obs(), {3'b100, 6'b010100, 1'b1});
    endtask

    task automatic t_overrun();
        do_reset();
        ev_rx_stop = 1; step();
        ev_rx_stop = 1; clr_rx_read = 1; step();
        chk("R7 read with stop: no overrun", obs(), {3'b000, 6'b010001, 1'b0});
        ev_rx_stop = 1; step();
        chk("R7 overrun keeps full", obs(), {3'b000, 6'b010011, 1'b0});
        set_en(3'b100);
        clr_rx_read = 1; step();
        chk("R9 overrun alone holds irq", obs(), {3'b100, 6'b010010, 1'b1});
        clr_err = 1; step();
        chk("R8 overrun cleared", obs(), {3'b100, 6'b010000, 1'b0});
    endtask

    initial begin
        rst = 1; idle();
        t_reset();
        t_tx();
        t_tx_collide();
        t_rx_good();
        t_rx_err();
        t_overrun();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule